// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block holds the control and status register that governs how a CPU rewrites its own program memory, together with the small sequencer behind it. Software arms a command by writing the register. The next store-to-program-memory or load-from-program-memory instruction, within a short cycle-counted window, then takes on the armed meaning. Possible meanings are a word write into the temporary page buffer, a page erase, a page write, a read of lock, fuse or signature data, or the section-enable step.

If the window runs out, the command disarms without any side effect. An erase or a write holds the CPU halted until the flash array model reports completion. A level-sensitive ready interrupt tells software when the controller can take a new command.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: A valid command write arms the controller for four clock cycles: a store whose strobe is sampled at any of the four rising edges after the write edge is accepted. If no store arrives by the fourth edge, the whole command, enable bit included, clears. A new valid write restarts the window.
- R2: A write is accepted only when the low five bits are 0x01, 0x03, 0x05, 0x09 or 0x11, and bit 5 may be set only together with low bits 0x01. Any other value leaves the command bits unchanged. Bit 7 (interrupt enable) is written on every register write. A write is ignored while an erase or write is running.
- R3: With the enable bit alone armed (0x01), a store raises `buf_we` in the same cycle. It presents word index Z[5:1] on `buf_addr` and the 16-bit data word on `buf_wdata`; Z bit 0 is ignored. The command then clears.
- R4: With 0x03 (erase) or 0x05 (write) armed, a store produces a one-cycle `fl_erase_start` or `fl_write_start` pulse in the next cycle. `fl_page` carries Z[15:6], the data word is ignored, and `cpu_halt` is high from that cycle until the cycle after `fl_done`.
- R5: During an erase or write, the enable bit (bit 0) and the command bit read back as 1. The edge that samples `fl_done` clears both.
- R6: With 0x09 armed, a load sampled within three edges of the write returns `lock_bits` when Z[0]=0 and `fuse_bits` when Z[0]=1. Outside that window, or with no special command, a load returns `flash_rdata`.
- R7: With 0x21 armed, a load within three edges returns `sig_byte`. A store in the window has no effect: no buffer write, no flash start, and the command is not cleared.
- R8: An accepted 0x11 write pulses `buf_clr` in that cycle if the buffer has taken a word since the last clear or completed page write. A store under 0x11 or 0x09 only clears the command.
- R9: `rdy_irq` is high exactly when bit 7 is set, `gie` is high, the enable bit is clear and `ee_busy` is low.
- R10: Register bit 6 always reads 0. The read layout is: bit7 interrupt enable, bit5 signature, bit4 buffer clear, bit3 lock read, bit2 page write, bit1 page erase, bit0 enable.
- R11: After reset the register reads 0x00, all strobes are low and `cpu_halt` is low. A store sampled in the same cycle as a register write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| gie | input | 1 | CPU global interrupt flag |
| ee_busy | input | 1 | EEPROM write in progress |
| cpu_store | input | 1 | Store-to-program-memory instruction strobe |
| cpu_load | input | 1 | Load-from-program-memory instruction strobe |
| z_ptr | input | 16 | Z pointer |
| st_data | input | 16 | Data word of the store |
| flash_rdata | input | 8 | Normal flash byte for a load |
| lock_bits | input | 8 | Lock byte |
| fuse_bits | input | 8 | Fuse byte |
| sig_byte | input | 8 | Signature row byte |
| ld_data | output | 8 | Byte returned to the load |
| buf_we | output | 1 | Page buffer word write |
| buf_addr | output | 5 | Page buffer word index |
| buf_wdata | output | 16 | Page buffer write data |
| buf_clr | output | 1 | Clear the whole page buffer |
| fl_erase_start | output | 1 | Start page erase (pulse) |
| fl_write_start | output | 1 | Start page write (pulse) |
| fl_page | output | 10 | Page address of the operation |
| fl_done | input | 1 | Flash operation finished |
| cpu_halt | output | 1 | Hold the CPU |
| rdy_irq | output | 1 | Ready interrupt request (level) |

## Verification
A wrong command state shows on `reg_rdata` in the cycle after the faulty edge. It also flips `rdy_irq` at once through the enable bit. A window counter that is off by one shows as a store that is wrongly accepted or wrongly dropped exactly at the fourth edge, or as a load at the third edge that returns the wrong byte. A stuck busy flag shows as `cpu_halt` still high in the cycle after `fl_done`. The reference model is compared against every output in every cycle, so any such divergence is caught within one clock.

// File: rtl/flash_sp_pkg.sv
package flash_sp_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_FILL = 3'd1,
    CMD_SECT = 3'd2,
    CMD_LOCK = 3'd3,
    CMD_PGWR = 3'd4,
    CMD_PGER = 3'd5,
    CMD_SIG  = 3'd6
  } sp_cmd_e;

  typedef struct packed {
    logic    ok;
    sp_cmd_e cmd;
  } sp_dec_t;

  // Map a register write value onto an armed command.
  function automatic sp_dec_t decode_wr(input logic [7:0] v);
    sp_dec_t d;
    d.ok  = 1'b1;
    d.cmd = CMD_NONE;
    case (v[4:0])
      5'h01:   d.cmd = v[5] ? CMD_SIG : CMD_FILL;
      5'h03:   d.cmd = CMD_PGER;
      5'h05:   d.cmd = CMD_PGWR;
      5'h09:   d.cmd = CMD_LOCK;
      5'h11:   d.cmd = CMD_SECT;
      default: d.ok  = 1'b0;
    endcase
    if (v[5] && v[4:0] != 5'h01) d.ok = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
  import flash_sp_pkg::*;
(
  input  logic [7:0] wdata,
  output logic       valid,
  output sp_cmd_e    cmd
);
  sp_dec_t d;
  always_comb begin
    d     = decode_wr(wdata);
    valid = d.ok;
    cmd   = d.cmd;
  end
endmodule

// File: rtl/sp_window_timer.sv
module sp_window_timer #(
  parameter int WIN    = 4,
  parameter int LD_WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic active,
  output logic load_ok,
  output logic expire
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);
  localparam logic [CW-1:0] LD_FLOOR = CW'(WIN - LD_WIN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (arm)           cnt <= WIN_C;
    else if (consume)       cnt <= '0;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active  = (cnt != '0);
  assign load_ok = (cnt > LD_FLOOR);
  assign expire  = (cnt == CW'(1)) && !arm && !consume;

  AST_WINDOW_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt <= $past(cnt))); // R1
endmodule

// File: rtl/sp_load_mux.sv
module sp_load_mux (
  input  logic       special,
  input  logic       pick_sig,
  input  logic       z0,
  input  logic [7:0] flash_rdata,
  input  logic [7:0] lock_bits,
  input  logic [7:0] fuse_bits,
  input  logic [7:0] sig_byte,
  output logic [7:0] ld_data
);
  always_comb begin
    if (!special)      ld_data = flash_rdata;
    else if (pick_sig) ld_data = sig_byte;
    else if (z0)       ld_data = fuse_bits;
    else               ld_data = lock_bits;
  end
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import flash_sp_pkg::*;
#(
  parameter int ZW          = 16,
  parameter int DW          = 16,
  parameter int PG_WORDS_LG = 5,
  parameter int WIN         = 4,
  parameter int LD_WIN      = 3,
  localparam int WORD_AW    = PG_WORDS_LG,
  localparam int PAGE_AW    = ZW - 1 - PG_WORDS_LG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               gie,
  input  logic               ee_busy,
  input  logic               cpu_store,
  input  logic               cpu_load,
  input  logic [ZW-1:0]      z_ptr,
  input  logic [DW-1:0]      st_data,
  input  logic [7:0]         flash_rdata,
  input  logic [7:0]         lock_bits,
  input  logic [7:0]         fuse_bits,
  input  logic [7:0]         sig_byte,
  output logic [7:0]         ld_data,
  output logic               buf_we,
  output logic [WORD_AW-1:0] buf_addr,
  output logic [DW-1:0]      buf_wdata,
  output logic               buf_clr,
  output logic               fl_erase_start,
  output logic               fl_write_start,
  output logic [PAGE_AW-1:0] fl_page,
  input  logic               fl_done,
  output logic               cpu_halt,
  output logic               rdy_irq
);

  function automatic logic [WORD_AW-1:0] word_of(input logic [ZW-1:0] z);
    return z[WORD_AW:1];
  endfunction

  function automatic logic [PAGE_AW-1:0] page_of(input logic [ZW-1:0] z);
    return z[ZW-1:WORD_AW+1];
  endfunction

  sp_cmd_e cmd_q, dec_cmd;
  logic    dec_ok, irq_en_q, busy_q, filled_q;
  logic    win_active, win_load_ok, win_expire;

  // Named internal events
  logic wr_take, st_take, st_consume, fill_evt, op_evt, op_done;

  sp_cmd_decode u_dec (.wdata(reg_wdata), .valid(dec_ok), .cmd(dec_cmd));

  assign wr_take    = reg_we && dec_ok && !busy_q;
  // A store in the same cycle as a register write is dropped.
  assign st_take    = cpu_store && win_active && !reg_we && !busy_q;
  assign st_consume = st_take && (cmd_q != CMD_SIG);
  assign fill_evt   = st_take && (cmd_q == CMD_FILL);
  assign op_evt     = st_take && (cmd_q == CMD_PGWR || cmd_q == CMD_PGER);
  assign op_done    = busy_q && fl_done;

  sp_window_timer #(.WIN(WIN), .LD_WIN(LD_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(wr_take), .consume(st_consume),
    .active(win_active), .load_ok(win_load_ok), .expire(win_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q          <= CMD_NONE;
      irq_en_q       <= 1'b0;
      busy_q         <= 1'b0;
      filled_q       <= 1'b0;
      fl_erase_start <= 1'b0;
      fl_write_start <= 1'b0;
      fl_page        <= '0;
    end else begin
      fl_erase_start <= 1'b0;
      fl_write_start <= 1'b0;
      if (reg_we) irq_en_q <= reg_wdata[7];
      if (wr_take) begin
        cmd_q <= dec_cmd;
        if (buf_clr) filled_q <= 1'b0;
      end else if (op_done) begin
        if (cmd_q == CMD_PGWR) filled_q <= 1'b0;
        cmd_q  <= CMD_NONE;
        busy_q <= 1'b0;
      end else if (op_evt) begin
        busy_q         <= 1'b1;
        fl_page        <= page_of(z_ptr);
        fl_erase_start <= (cmd_q == CMD_PGER);
        fl_write_start <= (cmd_q == CMD_PGWR);
      end else if (st_consume) begin
        if (fill_evt) filled_q <= 1'b1;
        cmd_q <= CMD_NONE;
      end else if (win_expire) begin
        cmd_q <= CMD_NONE;
      end
    end
  end

  assign buf_we    = fill_evt;
  assign buf_addr  = word_of(z_ptr);
  assign buf_wdata = st_data;
  assign buf_clr   = wr_take && (dec_cmd == CMD_SECT) && filled_q;
  assign cpu_halt  = busy_q;

  logic enable_bit;
  assign enable_bit = (cmd_q != CMD_NONE);
  assign reg_rdata  = {irq_en_q, 1'b0, cmd_q == CMD_SIG, cmd_q == CMD_SECT,
                       cmd_q == CMD_LOCK, cmd_q == CMD_PGWR, cmd_q == CMD_PGER,
                       enable_bit};
  assign rdy_irq    = irq_en_q && gie && !enable_bit && !ee_busy;

  sp_load_mux u_ld (
    .special(cpu_load && win_load_ok && (cmd_q == CMD_LOCK || cmd_q == CMD_SIG)),
    .pick_sig(cmd_q == CMD_SIG), .z0(z_ptr[0]),
    .flash_rdata(flash_rdata), .lock_bits(lock_bits), .fuse_bits(fuse_bits),
    .sig_byte(sig_byte), .ld_data(ld_data)
  );

  AST_BUSY_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6] == 1'b0); // R10
  AST_HALT_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> reg_rdata[0]); // R5
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_erase_start, fl_write_start, buf_we})); // R4
  AST_START_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_erase_start || fl_write_start) |-> cpu_halt); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_irq |-> (!ee_busy && !cpu_halt && !reg_rdata[0])); // R9
  AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !reg_we) |=> !reg_rdata[0] || $past(reg_we)); // R3
  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !dec_ok && !busy_q && !win_active) |=> $stable(reg_rdata[5:0])); // R2
endmodule

// File: tb/flash_selfprog_ctrl_test.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 0, gie = 0, ee_busy = 0, cpu_store = 0, cpu_load = 0, fl_done = 0;
  logic [7:0]  reg_wdata = 0, flash_rdata = 8'h5A, lock_bits = 8'hC3, fuse_bits = 8'h7E, sig_byte = 8'h1E;
  logic [15:0] z_ptr = 0, st_data = 0;
  logic [7:0]  reg_rdata, ld_data;
  logic        buf_we, buf_clr, fl_erase_start, fl_write_start, cpu_halt, rdy_irq;
  logic [4:0]  buf_addr;
  logic [15:0] buf_wdata;
  logic [9:0]  fl_page;

  flash_selfprog_ctrl uut (.*);

  int n_chk = 0, n_bad = 0;
  // model state: cmd 0 none,1 fill,2 sect,3 lock,4 write,5 erase,6 sig
  int m_cmd = 0, m_win = 0, m_busy = 0, m_irq = 0, m_fill = 0, m_bcnt = 0;
  int m_ser = 0, m_swr = 0, m_page = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic int dec(input logic [7:0] v);
    if (v[5] && v[4:0] != 5'h01) return -1;
    case (v[4:0])
      5'h01: return v[5] ? 6 : 1;
      5'h03: return 5;
      5'h05: return 4;
      5'h09: return 3;
      5'h11: return 2;
      default: return -1;
    endcase
  endfunction

  // One clock: compare now, then advance the model at the edge.
  task automatic tick();
    int d; bit acc, st, spec; logic [7:0] eld, erd;
    fl_done = (m_busy != 0 && m_bcnt == 5);
    #1;
    d    = dec(reg_wdata);
    acc  = reg_we && d >= 0 && m_busy == 0;
    st   = cpu_store && m_win > 0 && !reg_we && m_busy == 0;
    spec = cpu_load && m_win >= 2 && (m_cmd == 3 || m_cmd == 6);
    eld  = !spec ? flash_rdata : (m_cmd == 6 ? sig_byte : (z_ptr[0] ? fuse_bits : lock_bits));
    erd  = {m_irq[0], 1'b0, m_cmd == 6, m_cmd == 2, m_cmd == 3, m_cmd == 4, m_cmd == 5, m_cmd != 0};
    if (rst_n) begin
      chk("R10 R2 R5 reg_rdata", reg_rdata, erd);
      chk("R9 rdy_irq", rdy_irq, m_irq != 0 && gie && m_cmd == 0 && !ee_busy);
      chk("R3 buf_we", buf_we, st && m_cmd == 1);
      if (st && m_cmd == 1) begin
        chk("R3 buf_addr", buf_addr, z_ptr[5:1]);
        chk("R3 buf_wdata", buf_wdata, st_data);
      end
      chk("R8 buf_clr", buf_clr, acc && d == 2 && m_fill != 0);
      chk("R6 R7 ld_data", ld_data, eld);
      chk("R4 halt", cpu_halt, m_busy != 0);
      chk("R4 erase_start", fl_erase_start, m_ser != 0);
      chk("R4 write_start", fl_write_start, m_swr != 0);
      if (m_ser != 0 || m_swr != 0) chk("R4 page", fl_page, m_page);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_cmd = 0; m_win = 0; m_busy = 0; m_irq = 0; m_fill = 0; m_ser = 0; m_swr = 0; m_bcnt = 0;
    end else begin
      m_ser = 0; m_swr = 0;
      if (m_busy != 0) m_bcnt++;
      if (reg_we) m_irq = reg_wdata[7];
      if (acc) begin
        if (d == 2 && m_fill != 0) m_fill = 0;
        m_cmd = d; m_win = 4;
      end else if (m_busy != 0 && fl_done) begin
        if (m_cmd == 4) m_fill = 0;
        m_cmd = 0; m_busy = 0;
      end else if (st && (m_cmd == 4 || m_cmd == 5)) begin
        m_busy = 1; m_bcnt = 0; m_win = 0; m_page = z_ptr[15:6];
        if (m_cmd == 5) m_ser = 1; else m_swr = 1;
      end else if (st && m_cmd != 6) begin
        if (m_cmd == 1) m_fill = 1;
        m_cmd = 0; m_win = 0;
      end else if (m_win > 0) begin
        if (m_win == 1) begin m_cmd = 0; m_win = 0; end
        else m_win--;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1; reg_wdata = v; tick(); reg_we = 0;
  endtask

  task automatic store(input logic [15:0] z, input logic [15:0] dat);
    cpu_store = 1; z_ptr = z; st_data = dat; tick(); cpu_store = 0;
  endtask

  task automatic load(input logic [15:0] z);
    cpu_load = 1; z_ptr = z; tick(); cpu_load = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    // R11 reset state
    #1 chk("R11 reset rdata", reg_rdata, 8'h00);
    chk("R11 reset halt", cpu_halt, 1'b0);
    idle(1);
    // R9 interrupt level
    gie = 1; wr(8'h80); idle(2);
    ee_busy = 1; idle(2); ee_busy = 0; gie = 0; idle(1); gie = 1;
    // R3 fill, Z bit 0 ignored
    wr(8'h81); idle(1); store(16'h0047, 16'hBEEF); idle(2);
    // R1 store on the fourth edge accepted, fifth dropped
    wr(8'h01); idle(3); store(16'h0004, 16'h1234);
    wr(8'h01); idle(4); store(16'h0006, 16'h4321); idle(1);
    // R1 rewrite restarts window
    wr(8'h01); idle(3); wr(8'h01); idle(3); store(16'h0010, 16'hAAAA);
    // R2 invalid values ignored
    wr(8'h00); wr(8'h07); wr(8'h1F); wr(8'h23); idle(1);
    wr(8'h01); wr(8'h06); idle(1); store(16'h0002, 16'h0F0F);
    // R11 store with a write in the same cycle is dropped
    wr(8'h01); cpu_store = 1; reg_we = 1; reg_wdata = 8'h01; tick(); reg_we = 0; cpu_store = 0; idle(5);
    // R8 buffer clear only when filled
    wr(8'h11); idle(1); store(16'h0000, 16'h0);
    wr(8'h01); store(16'h0020, 16'h5555); wr(8'h11); idle(5);
    // R4 R5 erase
    wr(8'h03); idle(1); store(16'h1240, 16'hFFFF);
    wr(8'h05); idle(8);
    // R4 R5 write, fills cleared afterwards
    wr(8'h01); store(16'h0002, 16'h7777);
    wr(8'h05); store(16'hFFC1, 16'h0000); idle(8);
    wr(8'h11); idle(2);
    // R6 lock and fuse reads
    wr(8'h09); load(16'h0000); idle(1); load(16'h0001); load(16'h0001); idle(2);
    wr(8'h09); store(16'h0, 16'h0); load(16'h0); idle(1);
    // R7 signature
    wr(8'h21); store(16'h0008, 16'h9999); load(16'h0003); load(16'h0); load(16'h0); idle(2);
    finish_run();
  end
endmodule